// File: doc/BRIEF.md
# First-Hit Channel Address Encoder

This block watches a bank of 64 detector channels, each of which delivers two synchronous single-cycle strobes: one when its signal crosses threshold and one when its peak has been found. A mode input picks which of the two kinds of strobe the encoder listens to. The first selected strobe to arrive wins. The block then raises an event flag and presents the 6-bit index of the winning channel. If several channels fire in that same first cycle, the lowest index is reported.

Once it has captured an event, the encoder holds the flag and the address for a fixed number of clock cycles. The default is two cycles, roughly 40 ns at a 50 MHz clock. During that window it ignores every further strobe. It then drops the flag, returns the address to zero and rearms by itself. An enable input gates capture. A synchronous reset abandons any capture in progress.

Top module: `first_hit_addr_enc`

## Requirements
- R1: With `peak_mode` = 0, threshold strobes (`thr_stb`) trigger capture and peak strobes (`pk_stb`) have no effect on the outputs.
- R2: With `peak_mode` = 1, peak strobes (`pk_stb`) trigger capture and threshold strobes (`thr_stb`) have no effect on the outputs.
- R3: Suppose a selected strobe on channel k is high during the clock edge at which the block is armed. Then `hit_flag` is high after that edge and `hit_addr` equals k, where bit k of the strobe vector is channel k.
- R4: When several selected strobes are high in the capturing cycle, `hit_addr` reports the lowest channel index among them.
- R5: After a capture, `hit_flag` stays high for exactly HOLD_CYC cycles (default 2) with `hit_addr` unchanged. Then `hit_flag` goes low and `hit_addr` returns to zero.
- R6: Strobes that arrive while `hit_flag` is high are ignored. A strobe in the first cycle after `hit_flag` falls is captured.
- R7: While `arm_en` is low, `hit_flag` is low, `hit_addr` is zero and strobes are ignored. Lowering `arm_en` during a hold clears both outputs at the next edge.
- R8: A synchronous active-high `rst` clears `hit_flag` and `hit_addr` at the next edge, including a capture in progress. A strobe in the first cycle after `rst` falls is captured.
- R9: `hit_flag` and `hit_addr` are registered. `hit_addr` is zero whenever `hit_flag` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| arm_en | input | 1 | Capture enable |
| peak_mode | input | 1 | 0: trigger on threshold strobes, 1: trigger on peak strobes |
| thr_stb | input | 64 | Per-channel threshold-crossing strobes, bit k is channel k |
| pk_stb | input | 64 | Per-channel peak-found strobes, bit k is channel k |
| hit_flag | output | 1 | High while a first-hit address is valid |
| hit_addr | output | 6 | Index of the first channel to fire |

## Verification
The hardest cases lie at the two edges of the hold window. A strobe in the last held cycle must be dropped, and a strobe in the very next cycle must be taken. Both depend on the exact cycle in which the internal counter expires. The stimulus fires one channel, then places a second strobe in each held cycle and a third in the first cycle after the flag falls. Only the third channel may appear on the address. Reset and enable are each dropped in the middle of a hold, and a strobe follows at once, to show that the block rearms with no dead cycle.

// File: rtl/fh_pkg.sv
package fh_pkg;

    localparam int FH_NCH    = 64;
    localparam int FH_ADDR_W = $clog2(FH_NCH);
    localparam int FH_HOLD   = 2;

    typedef logic [FH_ADDR_W-1:0] ch_idx_t;

    typedef struct packed {
        logic    valid;
        ch_idx_t idx;
    } hit_req_t;

    typedef enum logic {
        ST_ARMED = 1'b0,
        ST_HOLD  = 1'b1
    } hold_state_t;

    typedef enum logic {
        SRC_THRESH = 1'b0,
        SRC_PEAK   = 1'b1
    } trig_src_t;

endpackage

// File: rtl/fh_strobe_sel.sv
module fh_strobe_sel
    import fh_pkg::*;
#(
    parameter int N_CH = FH_NCH
) (
    input  logic            peak_mode,
    input  logic [N_CH-1:0] thr_stb,
    input  logic [N_CH-1:0] pk_stb,
    output logic [N_CH-1:0] sel_stb
);

    trig_src_t src;
    assign src = trig_src_t'(peak_mode);

    for (genvar g = 0; g < N_CH; g++) begin : g_ch
        assign sel_stb[g] = (src == SRC_PEAK) ? pk_stb[g] : thr_stb[g];
    end

endmodule

// File: rtl/fh_prio_enc.sv
module fh_prio_enc
    import fh_pkg::*;
#(
    parameter int N_CH = FH_NCH
) (
    input  logic [N_CH-1:0] req,
    output hit_req_t        hit
);

    always_comb begin
        hit.valid = |req;
        hit.idx   = '0;
        for (int i = N_CH - 1; i >= 0; i--) begin
            if (req[i]) begin
                hit.idx = ch_idx_t'(i);
            end
        end
    end

endmodule

// File: rtl/fh_hold_ctrl.sv
module fh_hold_ctrl
    import fh_pkg::*;
#(
    parameter int HOLD_CYC = FH_HOLD
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     arm_en,
    input  hit_req_t hit,
    output logic     flag,
    output ch_idx_t  addr
);

    localparam int CNT_W = (HOLD_CYC > 1) ? $clog2(HOLD_CYC) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HOLD_CYC - 1);

    hold_state_t      state;
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !arm_en) begin
            state <= ST_ARMED;
            cnt   <= '0;
            flag  <= 1'b0;
            addr  <= '0;
        end else begin
            case (state)
                ST_ARMED: begin
                    if (hit.valid) begin
                        state <= ST_HOLD;
                        cnt   <= '0;
                        flag  <= 1'b1;
                        addr  <= hit.idx;
                    end
                end
                ST_HOLD: begin
                    if (cnt == CNT_LAST) begin
                        state <= ST_ARMED;
                        cnt   <= '0;
                        flag  <= 1'b0;
                        addr  <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: begin
                    state <= ST_ARMED;
                    cnt   <= '0;
                    flag  <= 1'b0;
                    addr  <= '0;
                end
            endcase
        end
    end

    // R3
    capture_when_armed_chk: assert property (@(posedge clk) disable iff (rst)
        (!flag && arm_en && hit.valid) |=> flag);

    // R5
    addr_held_chk: assert property (@(posedge clk) disable iff (rst)
        (flag && $past(flag)) |-> $stable(addr));

    // R9
    addr_idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !flag |-> (addr == '0));

endmodule

// File: rtl/first_hit_addr_enc.sv
module first_hit_addr_enc
    import fh_pkg::*;
#(
    parameter int N_CH     = FH_NCH,
    parameter int HOLD_CYC = FH_HOLD
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    arm_en,
    input  logic                    peak_mode,
    input  logic [N_CH-1:0]         thr_stb,
    input  logic [N_CH-1:0]         pk_stb,
    output logic                    hit_flag,
    output logic [FH_ADDR_W-1:0]    hit_addr
);

    localparam int RUN_W = $clog2(HOLD_CYC + 2);

    logic [N_CH-1:0] sel_stb;
    hit_req_t        hit;

    fh_strobe_sel #(.N_CH(N_CH)) u_sel (
        .peak_mode (peak_mode),
        .thr_stb   (thr_stb),
        .pk_stb    (pk_stb),
        .sel_stb   (sel_stb)
    );

    fh_prio_enc #(.N_CH(N_CH)) u_enc (
        .req (sel_stb),
        .hit (hit)
    );

    fh_hold_ctrl #(.HOLD_CYC(HOLD_CYC)) u_hold (
        .clk    (clk),
        .rst    (rst),
        .arm_en (arm_en),
        .hit    (hit),
        .flag   (hit_flag),
        .addr   (hit_addr)
    );

    logic [RUN_W-1:0] flag_run;
    always_ff @(posedge clk) begin
        if (rst || !hit_flag) flag_run <= '0;
        else if (flag_run != RUN_W'(HOLD_CYC + 1)) flag_run <= flag_run + 1'b1;
    end

    // R5
    flag_run_len_chk: assert property (@(posedge clk) disable iff (rst)
        hit_flag |-> (flag_run < RUN_W'(HOLD_CYC)));

    // R7
    disarm_clears_chk: assert property (@(posedge clk) disable iff (rst)
        !arm_en |=> (!hit_flag && hit_addr == '0));

    // R8
    reset_clears_chk: assert property (@(posedge clk)
        rst |=> !hit_flag);

endmodule

// File: tb/first_hit_addr_enc_tb.sv
module first_hit_addr_enc_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NCH        = 64;
    localparam int WDOG_CYC   = 5000;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            arm_en = 1'b1;
    logic            peak_mode = 1'b0;
    logic [NCH-1:0]  thr_stb = '0;
    logic [NCH-1:0]  pk_stb = '0;
    logic            hit_flag;
    logic [5:0]      hit_addr;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    first_hit_addr_enc dut_i (
        .clk       (clk),
        .rst       (rst),
        .arm_en    (arm_en),
        .peak_mode (peak_mode),
        .thr_stb   (thr_stb),
        .pk_stb    (pk_stb),
        .hit_flag  (hit_flag),
        .hit_addr  (hit_addr)
    );

    task automatic chk(input string req, input logic f_exp, input int a_exp);
        n_chk++;
        if (hit_flag !== f_exp || int'(hit_addr) != a_exp) begin
            n_err++;
            $display("FAIL %s: flag=%0b addr=%0d expected flag=%0b addr=%0d",
                     req, hit_flag, hit_addr, f_exp, a_exp);
        end
    endtask

    // Called at a negedge: strobes live for one cycle, returns at next negedge.
    task automatic fire(input logic [NCH-1:0] t, input logic [NCH-1:0] p);
        thr_stb = t;
        pk_stb  = p;
        @(negedge clk);
        thr_stb = '0;
        pk_stb  = '0;
    endtask

    function automatic logic [NCH-1:0] bit_of(input int k);
        return {{(NCH-1){1'b0}}, 1'b1} << k;
    endfunction

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R8 reset state", 1'b0, 0);
    endtask

    task automatic t_thr_mode();
        peak_mode = 1'b0;
        fire('0, bit_of(20));
        chk("R1 peak strobe ignored in threshold mode", 1'b0, 0);
        fire(bit_of(20), '0);
        chk("R1 R3 threshold capture ch20", 1'b1, 20);
        settle();
    endtask

    task automatic t_peak_mode();
        peak_mode = 1'b1;
        fire(bit_of(9), '0);
        chk("R2 threshold strobe ignored in peak mode", 1'b0, 0);
        fire('0, bit_of(41));
        chk("R2 R3 peak capture ch41", 1'b1, 41);
        settle();
        peak_mode = 1'b0;
    endtask

    task automatic t_tie();
        fire(bit_of(63) | bit_of(17) | bit_of(33), '0);
        chk("R4 tie 17/33/63", 1'b1, 17);
        settle();
        fire(bit_of(0) | bit_of(63), '0);
        chk("R4 tie 0/63", 1'b1, 0);
        settle();
        fire(bit_of(63), '0);
        chk("R3 top channel 63", 1'b1, 63);
        settle();
    endtask

    task automatic t_hold();
        fire(bit_of(12), '0);
        chk("R5 hold cycle 1", 1'b1, 12);
        @(negedge clk);
        chk("R5 hold cycle 2", 1'b1, 12);
        @(negedge clk);
        chk("R5 R9 release", 1'b0, 0);
        settle();
    endtask

    task automatic t_ignore();
        fire(bit_of(10), '0);
        chk("R6 first capture ch10", 1'b1, 10);
        fire(bit_of(3), '0);
        chk("R6 strobe in hold cycle 1 ignored", 1'b1, 10);
        fire(bit_of(5), '0);
        chk("R6 strobe in last hold cycle ignored", 1'b0, 0);
        fire(bit_of(7), '0);
        chk("R6 rearm captures ch7", 1'b1, 7);
        settle();
    endtask

    task automatic t_enable();
        arm_en = 1'b0;
        fire(bit_of(30), '0);
        chk("R7 disabled ignores strobe", 1'b0, 0);
        arm_en = 1'b1;
        fire(bit_of(30), '0);
        chk("R7 enabled captures ch30", 1'b1, 30);
        arm_en = 1'b0;
        @(negedge clk);
        chk("R7 disable during hold clears", 1'b0, 0);
        arm_en = 1'b1;
        settle();
    endtask

    task automatic t_reset_mid();
        fire(bit_of(44), '0);
        chk("R8 capture ch44 before reset", 1'b1, 44);
        rst = 1'b1;
        @(negedge clk);
        chk("R8 reset clears hold", 1'b0, 0);
        rst = 1'b0;
        fire(bit_of(50), '0);
        chk("R8 immediate rearm ch50", 1'b1, 50);
        settle();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_thr_mode();
        t_peak_mode();
        t_tie();
        t_hold();
        t_ignore();
        t_enable();
        t_reset_mid();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (WDOG_CYC) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: run did not complete, actual=timeout expected=done");
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

endmodule